// File: doc/BRIEF.md
# Burst-of-Two SRAM Command Sequencer

This block is a synthesizable behavioural model of a single-bank, burst-of-two SRAM with separate data-in and data-out buses, together with its state and command decoding. It runs on a clock at twice the command rate. Each command slot is two ticks long. The first tick of a slot samples the strobes, the read address and the first write beat. The second tick samples the write address and the second write beat. A small internal array stands in for the storage, with two data words held at each address.

Read data leaves on `dout_o` as two beats. The first beat comes five slots after the command and the second comes one tick after that. NOP and write-only slots give a low output in the matching output slot. A register-write slot loads the address into a debug-visible mode register and leaves the output unchanged. Loopback mode sends the write beats back to the output with the same latency as a read. The reset input sets the block to its reset state whatever the other inputs are doing.

Top module: `sb2_sram_top`

## Requirements
- R1: While `rst_n_i` is low, `dout_o` is 0, `mode_reg_o` is 0 and `slot_half_o` is 0, whatever the other inputs are.
- R2: After reset, `slot_half_o` alternates on every tick. A value of 0 means the next rising edge samples the first half of a slot. A value of 1 means it samples the second half.
- R3: In memory mode (`reg_wr_i`=0, `loop_en_i`=0), `rd_n_i`=1 with `wr_n_i`=0 is a write-only slot. The first beat (held in the lower word) and the second beat are stored at the address sampled in the second half. The output is 0 for both beats of the matching output slot.
- R4: `rd_n_i`=0 with `wr_n_i`=1 is a read-only slot using the address sampled in the first half. The lower word appears on `dout_o` after the 10th rising edge that follows the command edge. The upper word appears after the 11th.
- R5: `rd_n_i`=0 with `wr_n_i`=0 does a read at the first-half address and a write at the second-half address in the same slot. The read data follows the timing of R4.
- R6: A combined read and write to the same address returns the data that was stored before that slot.
- R7: `rd_n_i`=1 with `wr_n_i`=1 is a NOP. Both beats of the matching output slot are 0.
- R8: `reg_wr_i`=1 with `rd_n_i`=0 is a register write. It loads the first-half address into `mode_reg_o`, writes nothing to the array, and leaves `dout_o` at its previous value for the matching output slot.
- R9: `reg_wr_i`=1 with `rd_n_i`=1 is a NOP. The output is 0, `mode_reg_o` is unchanged and the array is not written.
- R10: With `reg_wr_i`=0 and `loop_en_i`=1, the two write beats of the slot come back on `dout_o` with the timing of R4. The array is not accessed.
- R11: A reset flushes the output pipeline, so a read in flight when reset is asserted never reaches `dout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, two ticks per command slot |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_half_o | output | 1 | Half of the slot that the next edge samples (0 first, 1 second) |
| reg_wr_i | input | 1 | Register-write strobe, active high |
| loop_en_i | input | 1 | Loopback enable, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Read address in the first half, write address in the second half |
| din_i | input | DATA_W | First write beat in the first half, second beat in the second half |
| dout_o | output | DATA_W | Read data, loopback data, or low |
| mode_reg_o | output | ADDR_W | Debug view of the mode register |

## Verification
If the command register or the slot phase is wrong, the error shows on `dout_o` exactly five slots later. The result is a beat in the wrong half, a zero in place of data, or held data in place of a zero. A bad write commit stays hidden until a later read of that address, so the sequence reads every written address back after the register-write and loopback slots that must not touch the array. A mode-register fault shows on `mode_reg_o` in the same slot, and a missed pipeline flush shows as stale data within six slots of reset.

// File: rtl/sb2_pkg.sv
package sb2_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_WR,
    CMD_RD,
    CMD_RW,
    CMD_REGW,
    CMD_LOOP
  } cmd_e;

  typedef enum logic [1:0] {
    RES_LOW,
    RES_DATA,
    RES_HOLD
  } res_e;

  // State priority: register-write strobe first, then loopback, then memory.
  function automatic cmd_e decode_cmd(input logic reg_wr, input logic lbk,
                                      input logic rd_n, input logic wr_n);
    cmd_e c;
    if (reg_wr) begin
      c = rd_n ? CMD_NOP : CMD_REGW;
    end else if (lbk) begin
      c = CMD_LOOP;
    end else begin
      unique case ({rd_n, wr_n})
        2'b11:   c = CMD_NOP;
        2'b10:   c = CMD_WR;
        2'b01:   c = CMD_RD;
        default: c = CMD_RW;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sb2_cmd_decode.sv
module sb2_cmd_decode
  import sb2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              half_i,
  input  logic              reg_wr_i,
  input  logic              loop_en_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] d1_o,
  output logic [ADDR_W-1:0] mode_reg_o
);

  cmd_e              cmd_q, cmd_d, dec;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [DATA_W-1:0] d1_q, d1_d;
  logic [ADDR_W-1:0] mode_q, mode_d;
  logic              cap_en;

  always_comb begin
    cap_en  = !half_i;
    dec     = decode_cmd(reg_wr_i, loop_en_i, rd_n_i, wr_n_i);
    cmd_d   = cmd_q;
    raddr_d = raddr_q;
    d1_d    = d1_q;
    mode_d  = mode_q;
    if (cap_en) begin
      cmd_d   = dec;
      raddr_d = addr_i;
      d1_d    = din_i;
      if (dec == CMD_REGW) mode_d = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cmd_q   <= CMD_NOP;
      raddr_q <= '0;
      d1_q    <= '0;
      mode_q  <= '0;
    end else begin
      cmd_q   <= cmd_d;
      raddr_q <= raddr_d;
      d1_q    <= d1_d;
      mode_q  <= mode_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign raddr_o    = raddr_q;
  assign d1_o       = d1_q;
  assign mode_reg_o = mode_q;

  // R9: only a first-half sample with the register-write strobe high and the read strobe low may move the mode register
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (half_i || rd_n_i || !reg_wr_i) |=> $stable(mode_reg_o));

  // R8: a register-write sample loads the first-half address
  p_mode_load_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!half_i && reg_wr_i && !rd_n_i) |=> (mode_reg_o == $past(addr_i)));

endmodule

// File: rtl/sb2_array.sv
module sb2_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LINE_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LINE_W-1:0] rdata_o
);

  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sb2_rd_pipe.sv
module sb2_rd_pipe
  import sb2_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAT_SLOTS = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              half_i,
  input  res_e              kind_i,
  input  logic [DATA_W-1:0] w0_i,
  input  logic [DATA_W-1:0] w1_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam int LAST = LAT_SLOTS - 1;

  res_e              kind_q [LAT_SLOTS];
  res_e              kind_d [LAT_SLOTS];
  logic [DATA_W-1:0] w0_q   [LAT_SLOTS];
  logic [DATA_W-1:0] w0_d   [LAT_SLOTS];
  logic [DATA_W-1:0] w1_q   [LAT_SLOTS];
  logic [DATA_W-1:0] w1_d   [LAT_SLOTS];
  logic [DATA_W-1:0] dout_q, dout_d;

  // Stages advance once per slot, on the second-half edge.
  for (genvar g = 0; g < LAT_SLOTS; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign kind_d[g] = half_i ? kind_i : kind_q[g];
      assign w0_d[g]   = half_i ? w0_i   : w0_q[g];
      assign w1_d[g]   = half_i ? w1_i   : w1_q[g];
    end else begin : g_body
      assign kind_d[g] = half_i ? kind_q[g-1] : kind_q[g];
      assign w0_d[g]   = half_i ? w0_q[g-1]   : w0_q[g];
      assign w1_d[g]   = half_i ? w1_q[g-1]   : w1_q[g];
    end
  end

  always_comb begin
    dout_d = dout_q;
    unique case (kind_q[LAST])
      RES_LOW:  dout_d = '0;
      RES_DATA: dout_d = half_i ? w1_q[LAST] : w0_q[LAST];
      default:  dout_d = dout_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int s = 0; s < LAT_SLOTS; s++) begin
        kind_q[s] <= RES_LOW;
        w0_q[s]   <= '0;
        w1_q[s]   <= '0;
      end
      dout_q <= '0;
    end else begin
      for (int s = 0; s < LAT_SLOTS; s++) begin
        kind_q[s] <= kind_d[s];
        w0_q[s]   <= w0_d[s];
        w1_q[s]   <= w1_d[s];
      end
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  // R7: a low result at the pipe tail drives a zero beat on the next edge
  p_low_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (kind_q[LAST] == RES_LOW) |=> (dout_o == '0));

  // R8: a register-write result at the pipe tail keeps the output unchanged
  p_hold_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (kind_q[LAST] == RES_HOLD) |=> $stable(dout_o));

endmodule

// File: rtl/sb2_sram_top.sv
module sb2_sram_top
  import sb2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int RD_LAT_SLOTS = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  output logic              slot_half_o,
  input  logic              reg_wr_i,
  input  logic              loop_en_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [ADDR_W-1:0] mode_reg_o
);

  localparam int LINE_W = 2 * DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              half_q, half_d;
  cmd_e              cmd;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] d1;
  logic              arr_we;
  logic [LINE_W-1:0] arr_wdata, arr_rdata;
  res_e              res_kind;
  logic [DATA_W-1:0] res_w0, res_w1;

  // Reset asserts at once and releases two ticks later.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign half_d = ~half_q;
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) half_q <= 1'b0;
    else            half_q <= half_d;
  end
  assign slot_half_o = half_q;

  sb2_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i      (clk_i),
    .rst_n_i    (rst_int_n),
    .half_i     (half_q),
    .reg_wr_i   (reg_wr_i),
    .loop_en_i  (loop_en_i),
    .rd_n_i     (rd_n_i),
    .wr_n_i     (wr_n_i),
    .addr_i     (addr_i),
    .din_i      (din_i),
    .cmd_o      (cmd),
    .raddr_o    (raddr),
    .d1_o       (d1),
    .mode_reg_o (mode_reg_o)
  );

  // The second-half edge commits the write. The read uses the array contents from before that edge.
  assign arr_we    = half_q && ((cmd == CMD_WR) || (cmd == CMD_RW));
  assign arr_wdata = {din_i, d1};

  sb2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i (addr_i),
    .wdata_i (arr_wdata),
    .raddr_i (raddr),
    .rdata_o (arr_rdata)
  );

  always_comb begin
    res_kind = RES_LOW;
    res_w0   = '0;
    res_w1   = '0;
    unique case (cmd)
      CMD_RD, CMD_RW: begin
        res_kind = RES_DATA;
        res_w0   = arr_rdata[DATA_W-1:0];
        res_w1   = arr_rdata[LINE_W-1:DATA_W];
      end
      CMD_LOOP: begin
        res_kind = RES_DATA;
        res_w0   = d1;
        res_w1   = din_i;
      end
      CMD_REGW: res_kind = RES_HOLD;
      default:  res_kind = RES_LOW;
    endcase
  end

  sb2_rd_pipe #(.DATA_W(DATA_W), .LAT_SLOTS(RD_LAT_SLOTS)) u_pipe (
    .clk_i   (clk_i),
    .rst_n_i (rst_int_n),
    .half_i  (half_q),
    .kind_i  (res_kind),
    .w0_i    (res_w0),
    .w1_i    (res_w1),
    .dout_o  (dout_o)
  );

  // R2: slot halves alternate once out of reset
  p_half_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    1'b1 |=> (slot_half_o != $past(slot_half_o)));

  // R10: loopback and register-write slots never reach the array
  p_no_array_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((cmd == CMD_LOOP) || (cmd == CMD_REGW)) |-> !arr_we);

  // R1: reset holds the output low
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_n_i |-> (dout_o == '0));

endmodule

// File: tb/sb2_sram_top_tb_top.sv
module sb2_sram_top_tb_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LAT = 5;
  localparam int NV = 21;

  // Layout: [27] reg_wr [26] loop_en [25] rd_n [24] wr_n
  //         [23:20] read addr [19:16] write addr [15:8] beat1 [7:0] beat2
  localparam logic [27:0] VEC [NV] = '{
    28'h2031122,  // write only @3
    28'h2053344,  // write only @5
    28'h1300000,  // read @3
    28'h0565566,  // read @5 + write @6
    28'h0337788,  // read @3 + write @3 (same address)
    28'h1300000,  // read @3
    28'h1600000,  // read @6
    28'h895AABB,  // register write addr 9 (write strobe low too)
    28'hAA5CCDD,  // reg_wr with read high: NOP
    28'h605EEFF,  // loopback
    28'h4331234,  // loopback with both strobes low
    28'h1500000,  // read @5
    28'h1300000,  // read @3
    28'h3000000,  // NOP
    28'h8200000,  // register write addr 2
    28'h1600000,  // read @6
    28'h3000000,
    28'h3000000,
    28'h3000000,
    28'h3000000,
    28'h3000000
  };

  logic          clk_i = 1'b0;
  logic          rst_n_i;
  logic          slot_half_o;
  logic          reg_wr_i, loop_en_i, rd_n_i, wr_n_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] din_i;
  logic [DW-1:0] dout_o;
  logic [AW-1:0] mode_reg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_lo [16];
  logic [DW-1:0] ref_hi [16];
  logic [DW-1:0] exp_q1 [NV];
  logic [DW-1:0] exp_q2 [NV];
  string         exp_tag [NV];
  logic [DW-1:0] last_q;
  logic [AW-1:0] mode_m;

  always #10 clk_i = ~clk_i;

  sb2_sram_top #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT_SLOTS(LAT)) dut_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .slot_half_o (slot_half_o),
    .reg_wr_i    (reg_wr_i),
    .loop_en_i   (loop_en_i),
    .rd_n_i      (rd_n_i),
    .wr_n_i      (wr_n_i),
    .addr_i      (addr_i),
    .din_i       (din_i),
    .dout_o      (dout_o),
    .mode_reg_o  (mode_reg_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_nop();
    reg_wr_i = 1'b0; loop_en_i = 1'b0; rd_n_i = 1'b1; wr_n_i = 1'b1;
    addr_i = '0; din_i = '0;
  endtask

  // Starts and ends at a falling edge where slot_half_o is 0.
  task automatic run_slot(input logic [27:0] v, output logic [DW-1:0] s1,
                          output logic [DW-1:0] s2, output logic h);
    reg_wr_i  = v[27];
    loop_en_i = v[26];
    rd_n_i    = v[25];
    wr_n_i    = v[24];
    addr_i    = v[23:20];
    din_i     = v[15:8];
    @(negedge clk_i);
    s1 = dout_o;
    h  = slot_half_o;
    addr_i = v[19:16];
    din_i  = v[7:0];
    @(negedge clk_i);
    s2 = dout_o;
  endtask

  task automatic align();
    repeat (3) @(negedge clk_i);
    while (slot_half_o !== 1'b0) @(negedge clk_i);
  endtask

  // Reference model, written from the requirements.
  task automatic model(input logic [27:0] v, input int i);
    logic rw, lb, rn, wn;
    logic [AW-1:0] ra, wa;
    rw = v[27]; lb = v[26]; rn = v[25]; wn = v[24];
    ra = v[23:20]; wa = v[19:16];
    if (rw && !rn) begin
      exp_q1[i] = last_q; exp_q2[i] = last_q; exp_tag[i] = "R8";
      mode_m = ra;
    end else if (rw) begin
      exp_q1[i] = '0; exp_q2[i] = '0; exp_tag[i] = "R9";
    end else if (lb) begin
      exp_q1[i] = v[15:8]; exp_q2[i] = v[7:0]; exp_tag[i] = "R10";
    end else begin
      if (!rn) begin
        exp_q1[i] = ref_lo[ra]; exp_q2[i] = ref_hi[ra];
        exp_tag[i] = wn ? "R4" : ((ra == wa) ? "R6" : "R5");
      end else begin
        exp_q1[i] = '0; exp_q2[i] = '0;
        exp_tag[i] = wn ? "R7" : "R3";
      end
      if (!wn) begin
        ref_lo[wa] = v[15:8];
        ref_hi[wa] = v[7:0];
      end
    end
    last_q = exp_q2[i];
  endtask

  initial begin
    logic [DW-1:0] s1, s2;
    logic h;
    set_nop();
    rst_n_i = 1'b0;
    last_q = '0;
    mode_m = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 dout in reset", dout_o, 0);
    check("R1 mode in reset", mode_reg_o, 0);
    check("R1 half in reset", slot_half_o, 0);
    rst_n_i = 1'b1;
    align();

    for (int i = 0; i < NV; i++) begin
      model(VEC[i], i);
      run_slot(VEC[i], s1, s2, h);
      check("R2 second half flag", h, 1);
      if (i >= LAT) begin
        check({exp_tag[i-LAT], " beat1"}, s1, exp_q1[i-LAT]);
        check({exp_tag[i-LAT], " beat2"}, s2, exp_q2[i-LAT]);
      end
      check("R8/R9 mode register", mode_reg_o, mode_m);
    end

    // R11: a read in flight is flushed by reset
    run_slot(28'h1300000, s1, s2, h);
    run_slot(28'h3000000, s1, s2, h);
    set_nop();
    rst_n_i = 1'b0;
    @(negedge clk_i);
    check("R1 dout after async reset", dout_o, 0);
    check("R1 mode after async reset", mode_reg_o, 0);
    check("R1 half after async reset", slot_half_o, 0);
    rst_n_i = 1'b1;
    align();
    for (int k = 0; k < 6; k++) begin
      run_slot(28'h3000000, s1, s2, h);
      check("R11 flushed beat1", s1, 0);
      check("R11 flushed beat2", s2, 0);
    end

    // R10: the loopback slot did not write @5 after reset either
    for (int k = 0; k < LAT + 1; k++) begin
      run_slot((k == 0) ? 28'h1500000 : 28'h3000000, s1, s2, h);
    end
    check("R10 array untouched beat1", s1, 8'h33);
    check("R10 array untouched beat2", s2, 8'h44);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule